// File: doc/BRIEF.md
# MDIO Management Master with Link Autopoll

This block drives a two-wire management bus to an external Ethernet PHY. It has a free-running management clock (MDC) produced by a programmable divider, and it drives the data line (MDIO) through a separate output and output-enable pair that a pad tristate buffer uses. Software uses a small four-register port to issue single reads and writes to any PHY register. Each transaction is a full frame: a 32-bit preamble, start, opcode, PHY address, register address, turnaround and 16 data bits.

When autopoll is enabled, a background engine reads register 1 of the programmed PHY again and again. It compares bit 2 of each result (the link indication) with a stored copy of the link state. A change sets one of two sticky status bits, one for link gained and one for link lost. Each status bit can be passed to the interrupt line through a mask. Host transactions and polls share the one bus, and a busy flag shows when the bus is in use.

The control state machine has four states. CTL_IDLE goes to CTL_HOST when a host start is pending. Otherwise it goes to CTL_POLL when autopoll is enabled. CTL_HOST returns to CTL_IDLE when its frame ends. CTL_POLL goes to CTL_GAP when its frame ends. CTL_GAP returns to CTL_IDLE when its spacing counter reaches zero, or at once when a host start is pending.

The frame engine also has four states. ENG_IDLE goes to ENG_ALIGN when it gets a go. ENG_ALIGN goes to ENG_SHIFT on the first falling MDC edge. ENG_SHIFT goes to ENG_FINISH on the falling edge that ends bit 63. ENG_FINISH always returns to ENG_IDLE after one cycle.

Top module: `mdio_autopoll_master`

## Requirements
- R1: After reset, CTRL reads 0, CFG reads 0x0000_0200 (divider 2, PHY address 0), STATUS reads 0, irq is 0 and mdio_oe is 0.
- R2: Each frame on the bus has these parts in this order: 32 ones, start 01, opcode (10 for a read, 01 for a write), the 5-bit PHY address from CFG[4:0], the 5-bit register address, the turnaround, then 16 data bits MSB first. On a write the block drives the turnaround as 10. On a read the block releases the line (mdio_oe=0) from the turnaround through the end of the frame.
- R3: MDC stays high, and stays low, for CFG[15:8]+1 clock cycles each. mdio_o changes only in the cycle where MDC falls. mdio_i is sampled as MDC rises.
- R4: A host write to CTRL with bit 24 (start) set starts a frame. CTRL bit 25 (busy) stays 1 while any frame, host or poll, is in progress. Bit 24 and bit 25 both read 1 until the host frame completes, and then both read 0.
- R5: CTRL bit 26 picks the operation (1 write, 0 read). CTRL[20:16] holds the register address and CTRL[15:0] the data. After a host read, CTRL[15:0] holds the value the PHY returned.
- R6: While busy is 1, a CTRL write changes only bit 28 (autopoll enable). Its data, register, operation and start fields are ignored.
- R7: With CTRL bit 28 set, the block reads register 1 of the CFG PHY address over and over. Polls never change CTRL[15:0].
- R8: The stored link state resets to down and is shown in STATUS bit 2. A poll that finds bit 2 of the returned value different from the stored state updates the stored state. It sets STATUS bit 0 for a change to up or STATUS bit 1 for a change to down.
- R9: Writing 1 to STATUS bit 0 or bit 1 clears that bit. An event that sets a bit in the same cycle as a clear of that bit wins.
- R10: irq is 1 exactly when some STATUS bit 0 or 1 is set and the matching MASK bit (MASK[0] for up, MASK[1] for down) is set.
- R11: Clearing CTRL bit 28 during a poll lets that poll run to completion with busy held high, and no further poll starts.
- R12: A host start accepted during the spacing between polls runs before the next poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 CTRL, 1 CFG, 2 STATUS, 3 MASK |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read select, same map as wr_addr |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Masked link-event interrupt |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data value to the pad driver |
| mdio_oe | output | 1 | Pad output enable, 1 drives mdio_o |
| mdio_i | input | 1 | Data value read back from the pad |

## Verification
The event that sets a status bit when a poll ends and a host write-one clear of that same bit can land on the same clock edge. To provoke this, the bench first changes the PHY model's link bit during the gap between polls. It then holds a clear of the matching status bit on every cycle of the next poll, and keeps it asserted through the edge where busy drops, which is the edge where the event is recorded. The bit must read as set afterwards. A second race, between a host start and the next automatic poll, is provoked by starting a host read during the spacing gap. It is judged by checking that the next frame the PHY model decodes carries the host's register address.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_HOST,
        CTL_POLL,
        CTL_GAP
    } ctl_state_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ALIGN,
        ENG_SHIFT,
        ENG_FINISH
    } eng_state_e;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_RD    = 2'b10;
    localparam logic [1:0] OP_WR    = 2'b01;
    localparam logic [1:0] TA_WR    = 2'b10;

    // Register select codes on the host port
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CFG  = 2'd1;
    localparam logic [1:0] SEL_STS  = 2'd2;
    localparam logic [1:0] SEL_MASK = 2'd3;

    // CTRL field positions
    localparam int CB_START = 24;
    localparam int CB_BUSY  = 25;
    localparam int CB_WRITE = 26;
    localparam int CB_APOLL = 28;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              is_wr,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regad,
        input logic [DATA_W-1:0] wdat
    );
        logic [1:0] op;
        logic [1:0] ta;
        op = is_wr ? OP_WR : OP_RD;
        ta = is_wr ? TA_WR : 2'b11;
        return {{PRE_BITS{1'b1}}, SOF_CODE, op, phy, regad, ta, wdat};
    endfunction

endpackage

// File: rtl/mdc_tick_gen.sv
module mdc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             expire;

    assign expire    = (cnt >= half_div);
    assign rise_tick = expire && !mdc;
    assign fall_tick = expire && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (expire) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_write,
    input  logic [ADDR_W-1:0] go_phy,
    input  logic [ADDR_W-1:0] go_reg,
    input  logic [DATA_W-1:0] go_wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    localparam int          CNT_W    = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(FRAME_BITS - DATA_W - 2);
    localparam logic [CNT_W-1:0] DATA_IDX = CNT_W'(FRAME_BITS - DATA_W);

    eng_state_e             st, st_nx;
    logic [FRAME_BITS-1:0]  frame;
    logic [CNT_W-1:0]       bitcnt;
    logic [CNT_W-1:0]       bit_nx;
    logic                   is_rd;

    assign bit_nx = bitcnt + 1'b1;
    assign done   = (st == ENG_FINISH);

    always_comb begin
        st_nx = st;
        unique case (st)
            ENG_IDLE:   if (go) st_nx = ENG_ALIGN;
            ENG_ALIGN:  if (fall_tick) st_nx = ENG_SHIFT;
            ENG_SHIFT:  if (fall_tick && bitcnt == LAST_IDX) st_nx = ENG_FINISH;
            ENG_FINISH: st_nx = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ENG_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame   <= '0;
            bitcnt  <= '0;
            is_rd   <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rdata   <= '0;
        end else begin
            unique case (st)
                ENG_IDLE: begin
                    if (go) begin
                        frame  <= build_frame(go_write, go_phy, go_reg, go_wdata);
                        is_rd  <= !go_write;
                        bitcnt <= '0;
                    end
                end
                ENG_ALIGN: begin
                    if (fall_tick) begin
                        mdio_o  <= frame[LAST_IDX];
                        mdio_oe <= 1'b1;
                    end
                end
                ENG_SHIFT: begin
                    if (rise_tick && is_rd && bitcnt >= DATA_IDX)
                        rdata <= {rdata[DATA_W-2:0], mdio_i};
                    if (fall_tick) begin
                        if (bitcnt == LAST_IDX) begin
                            mdio_o  <= 1'b1;
                            mdio_oe <= 1'b0;
                        end else begin
                            bitcnt  <= bit_nx;
                            mdio_o  <= frame[LAST_IDX - bit_nx];
                            mdio_oe <= !(is_rd && bit_nx >= TA_IDX);
                        end
                    end
                end
                ENG_FINISH: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/link_event_unit.sv
module link_event_unit #(
    parameter int LINK_BIT = 2,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_word,
    input  logic              clr_en,
    input  logic [1:0]        clr_bits,
    input  logic [1:0]        mask,
    output logic [1:0]        sts,
    output logic              link_q,
    output logic              ev_up,
    output logic              ev_dn,
    output logic              irq
);
    logic link_now;

    assign link_now = sample_word[LINK_BIT];
    assign ev_up    = sample_valid &&  link_now && !link_q;
    assign ev_dn    = sample_valid && !link_now &&  link_q;
    assign irq      = |(sts & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= 1'b0;
            sts    <= 2'b00;
        end else begin
            if (sample_valid) link_q <= link_now;
            sts[0] <= ev_up || (sts[0] && !(clr_en && clr_bits[0]));
            sts[1] <= ev_dn || (sts[1] && !(clr_en && clr_bits[1]));
        end
    end
endmodule

// File: rtl/mdio_autopoll_master.sv
module mdio_autopoll_master
    import mdio_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int DIV_RESET  = 2,
    parameter int POLL_GAP   = 16,
    parameter int STATUS_REG = 1,
    parameter int LINK_BIT   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam logic [ADDR_W-1:0] POLL_REG = ADDR_W'(STATUS_REG);

    ctl_state_e          ctl_st, ctl_nx;
    logic [GAP_W-1:0]    gap_cnt;

    logic                ap_en;
    logic                start_pend;
    logic                host_write;
    logic [ADDR_W-1:0]   host_reg;
    logic [DATA_W-1:0]   host_data;
    logic [ADDR_W-1:0]   phy_addr;
    logic [DIV_W-1:0]    half_div;
    logic [1:0]          mask;

    logic                rise_tick, fall_tick;
    logic                eng_go, eng_done;
    logic [DATA_W-1:0]   eng_rdata;
    logic                busy, poll_active;
    logic [1:0]          sts;
    logic                link_q, ev_up, ev_dn;

    logic                ctrl_wr, cfg_wr, sts_wr, mask_wr;
    wire                 unused_wr_bits = &{wr_data[31:29], wr_data[27],
                                            wr_data[25], wr_data[23:21]};

    assign ctrl_wr     = wr_en && wr_addr == SEL_CTRL;
    assign cfg_wr      = wr_en && wr_addr == SEL_CFG;
    assign sts_wr      = wr_en && wr_addr == SEL_STS;
    assign mask_wr     = wr_en && wr_addr == SEL_MASK;

    assign poll_active = (ctl_st == CTL_POLL);
    assign busy        = start_pend || (ctl_st == CTL_HOST) || poll_active;
    assign eng_go      = (ctl_st == CTL_IDLE) && (start_pend || ap_en);

    // Control state machine: next state
    always_comb begin
        ctl_nx = ctl_st;
        unique case (ctl_st)
            CTL_IDLE: begin
                if (start_pend)  ctl_nx = CTL_HOST;
                else if (ap_en)  ctl_nx = CTL_POLL;
            end
            CTL_HOST: if (eng_done) ctl_nx = CTL_IDLE;
            CTL_POLL: if (eng_done) ctl_nx = CTL_GAP;
            CTL_GAP:  if (start_pend || gap_cnt == '0) ctl_nx = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_st <= CTL_IDLE;
        else        ctl_st <= ctl_nx;
    end

    // Control state machine: outputs and host registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt    <= '0;
            ap_en      <= 1'b0;
            start_pend <= 1'b0;
            host_write <= 1'b0;
            host_reg   <= '0;
            host_data  <= '0;
            phy_addr   <= '0;
            half_div   <= DIV_W'(DIV_RESET);
            mask       <= 2'b00;
        end else begin
            if (ctl_st == CTL_POLL && eng_done)
                gap_cnt <= GAP_W'(POLL_GAP);
            else if (ctl_st == CTL_GAP && gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;

            if (ctrl_wr) begin
                ap_en <= wr_data[CB_APOLL];
                if (!busy) begin
                    host_data  <= wr_data[DATA_W-1:0];
                    host_reg   <= wr_data[16 +: ADDR_W];
                    host_write <= wr_data[CB_WRITE];
                    start_pend <= wr_data[CB_START];
                end
            end

            if (ctl_st == CTL_HOST && eng_done) begin
                start_pend <= 1'b0;
                if (!host_write) host_data <= eng_rdata;
            end

            if (cfg_wr) begin
                phy_addr <= wr_data[ADDR_W-1:0];
                half_div <= wr_data[8 +: DIV_W];
            end
            if (mask_wr) mask <= wr_data[1:0];
        end
    end

    always_comb begin
        unique case (rd_addr)
            SEL_CTRL: rd_data = {3'b000, ap_en, 1'b0, host_write, busy, start_pend,
                                 3'b000, host_reg, host_data};
            SEL_CFG:  rd_data = 32'({half_div, 3'b000, phy_addr});
            SEL_STS:  rd_data = {29'd0, link_q, sts};
            SEL_MASK: rd_data = {30'd0, mask};
        endcase
    end

    mdc_tick_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_div  (half_div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (eng_go),
        .go_write  (start_pend ? host_write : 1'b0),
        .go_phy    (phy_addr),
        .go_reg    (start_pend ? host_reg : POLL_REG),
        .go_wdata  (host_data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdata     (eng_rdata),
        .done      (eng_done)
    );

    link_event_unit #(.LINK_BIT(LINK_BIT), .DATA_W(DATA_W)) u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (poll_active && eng_done),
        .sample_word  (eng_rdata),
        .clr_en       (sts_wr),
        .clr_bits     (wr_data[1:0]),
        .mask         (mask),
        .sts          (sts),
        .link_q       (link_q),
        .ev_up        (ev_up),
        .ev_dn        (ev_dn),
        .irq          (irq)
    );
endmodule

// File: rtl/mdio_autopoll_checker.sv
module mdio_autopoll_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        eng_done,
    input logic        poll_active,
    input logic        ev_up,
    input logic        ev_dn,
    input logic [1:0]  sts,
    input logic [15:0] host_data
);
    p_oe_only_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    p_done_within_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> busy);

    p_mdio_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(mdc) |-> $stable(mdio_o));

    p_one_event_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_up && ev_dn));

    p_up_event_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_up |=> sts[0]);

    p_down_event_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dn |=> sts[1]);

    p_poll_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_active |=> $stable(host_data));
endmodule

bind mdio_autopoll_master mdio_autopoll_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .busy        (busy),
    .eng_done    (eng_done),
    .poll_active (poll_active),
    .ev_up       (ev_up),
    .ev_dn       (ev_dn),
    .sts         (sts),
    .host_data   (host_data)
);

// File: tb/mdio_autopoll_master_tb_top.sv
module mdio_autopoll_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        irq, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mdio_autopoll_master dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- PHY model ----------------
    logic [15:0] phy_regs [32];
    logic [63:0] psh = '0;
    int          pcnt = 0;
    int          rd_idx = 0;
    logic [15:0] rd_word = '0;
    logic [4:0]  last_phy = '0, last_reg = '0;
    int          frames = 0;
    int          frame_err = 0;

    always @(posedge mdc) begin
        if (mdio_oe) begin
            psh = {psh[62:0], mdio_o};
            pcnt++;
            if (pcnt == 46 && psh[11:10] == 2'b10) begin
                if (psh[45:14] != 32'hFFFF_FFFF || psh[13:12] != 2'b01) frame_err++;
                last_phy = psh[9:5];
                last_reg = psh[4:0];
                rd_word  = phy_regs[psh[4:0]];
                rd_idx   = 46;
                pcnt     = 0;
                frames++;
            end else if (pcnt == 64) begin
                if (psh[63:32] != 32'hFFFF_FFFF || psh[31:30] != 2'b01 ||
                    psh[29:28] != 2'b01 || psh[17:16] != 2'b10) frame_err++;
                last_phy = psh[27:23];
                last_reg = psh[22:18];
                phy_regs[psh[22:18]] = psh[15:0];
                pcnt = 0;
                frames++;
            end
        end
    end

    always @(negedge mdc) begin
        if (rd_idx > 0) begin
            if (rd_idx == 46)      mdio_i = 1'b1;
            else if (rd_idx == 47) mdio_i = 1'b0;
            else                   mdio_i = rd_word[63 - rd_idx];
            rd_idx++;
            if (rd_idx == 64) rd_idx = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_busy(input bit lvl);
        logic [31:0] v;
        rd(2'd0, v);
        while (v[25] != lvl) begin
            @(negedge clk);
            rd(2'd0, v);
        end
    endtask

    task automatic wait_sts(input int bitn);
        logic [31:0] v;
        int n = 0;
        rd(2'd2, v);
        while (!v[bitn] && n < 5000) begin
            @(negedge clk);
            rd(2'd2, v);
            n++;
        end
    endtask

    // ---------------- scoreboard ----------------
    logic [15:0] exp_q[$];
    logic [15:0] act_q[$];
    event        got_ev;

    initial begin
        forever begin
            @(got_ev);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [15:0] a, e;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                chk(a == e, "R5 host read data", {16'd0, a}, {16'd0, e});
            end
        end
    end

    task automatic host_read(input logic [4:0] r, input bit keep_ap);
        logic [31:0] v;
        exp_q.push_back(phy_regs[r]);
        wr(2'd0, (32'(keep_ap) << 28) | (32'd1 << 24) | (32'(r) << 16));
        wait_busy(1'b0);
        rd(2'd0, v);
        act_q.push_back(v[15:0]);
        -> got_ev;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [31:0] v;
        int f, n;
        for (int i = 0; i < 32; i++) phy_regs[i] = 16'(i * 16'h0101);
        phy_regs[1]  = 16'h0000;
        phy_regs[3]  = 16'h1234;
        phy_regs[17] = 16'hFFFF;
        phy_regs[30] = 16'h0000;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk(v == 32'd0, "R1 CTRL reset", v, 32'd0);
        rd(2'd1, v); chk(v == 32'h200, "R1 CFG reset", v, 32'h200);
        rd(2'd2, v); chk(v == 32'd0, "R1 STATUS reset", v, 32'd0);
        chk(irq == 1'b0 && mdio_oe == 1'b0, "R1 irq/oe reset", {30'd0, irq, mdio_oe}, 32'd0);

        // R3 MDC half period = divider + 1
        @(posedge mdc);
        n = 0;
        while (mdc) begin
            @(negedge clk);
            if (mdc) n++;
        end
        chk(n == 3, "R3 MDC high time", n, 3);

        wr(2'd1, {16'd0, 8'd2, 3'd0, 5'd5});

        // R2/R4 host write
        wr(2'd0, (32'd1 << 24) | (32'd1 << 26) | (32'd9 << 16) | 32'hA5C3);
        rd(2'd0, v);
        chk(v[25:24] == 2'b11, "R4 start/busy set", v[25:24], 2'b11);
        wait_busy(1'b0);
        rd(2'd0, v);
        chk(v[25:24] == 2'b00, "R4 start/busy clear", v[25:24], 2'b00);
        chk(phy_regs[9] == 16'hA5C3, "R2 write data", phy_regs[9], 16'hA5C3);
        chk(last_phy == 5'd5 && last_reg == 5'd9, "R2 write header", {last_phy, last_reg}, {5'd5, 5'd9});

        // R5 reads, several patterns
        host_read(5'd3, 1'b0);
        host_read(5'd17, 1'b0);
        host_read(5'd30, 1'b0);
        host_read(5'd9, 1'b0);

        // R6 CTRL write while busy is ignored
        exp_q.push_back(16'h1234);
        wr(2'd0, (32'd1 << 24) | (32'd3 << 16));
        f = frames;
        wr(2'd0, (32'd1 << 24) | (32'd1 << 26) | (32'd7 << 16) | 32'hDEAD);
        wait_busy(1'b0);
        rd(2'd0, v);
        act_q.push_back(v[15:0]); -> got_ev;
        chk(v[20:16] == 5'd3 && v[26] == 1'b0, "R6 fields kept", v, 32'h0003_1234);
        chk(frames == f + 1 && last_reg == 5'd3, "R6 no extra frame", frames - f, 1);

        // R7/R8/R10 autopoll, first link up
        wr(2'd3, 32'd3);
        phy_regs[1] = 16'h0004;
        wr(2'd0, (32'd1 << 28) | 32'h5A5A);
        wait_sts(0);
        rd(2'd2, v);
        chk(v[2:0] == 3'b101, "R8 link up event", v, 32'h5);
        chk(irq == 1'b1, "R10 irq on up", irq, 1);
        chk(last_reg == 5'd1 && last_phy == 5'd5, "R7 poll target", {last_phy, last_reg}, {5'd5, 5'd1});
        rd(2'd0, v);
        chk(v[15:0] == 16'h5A5A, "R7 data untouched", v[15:0], 16'h5A5A);

        // R9 write-one clear
        wr(2'd2, 32'd1);
        rd(2'd2, v);
        chk(v[2:0] == 3'b100, "R9 clear", v, 32'h4);
        chk(irq == 1'b0, "R10 irq after clear", irq, 0);

        // R10 masking
        wr(2'd3, 32'd2);
        phy_regs[1] = 16'h0000;
        wait_sts(1);
        rd(2'd2, v);
        chk(v[2:0] == 3'b010, "R8 link down event", v, 32'h2);
        chk(irq == 1'b1, "R10 irq on down", irq, 1);
        wr(2'd2, 32'd3);
        phy_regs[1] = 16'h0004;
        wait_sts(0);
        chk(irq == 1'b0, "R10 up masked", irq, 0);
        wr(2'd2, 32'd3);
        wr(2'd3, 32'd3);

        // R9 set wins over same-cycle clear
        wait_busy(1'b1);
        wait_busy(1'b0);
        phy_regs[1] = 16'h0000;
        wait_busy(1'b1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd2;
        rd(2'd0, v);
        while (v[25]) begin
            @(negedge clk);
            rd(2'd0, v);
        end
        wr_en = 1'b0;
        rd(2'd2, v);
        chk(v[1] == 1'b1, "R9 set wins", v, 32'h2);

        // R11 disable during a poll
        wait_busy(1'b1);
        wr(2'd0, 32'd0);
        rd(2'd0, v);
        chk(v[25] == 1'b1, "R11 poll still busy", v[25], 1);
        wait_busy(1'b0);
        f = frames;
        repeat (2000) @(negedge clk);
        rd(2'd0, v);
        chk(frames == f && v[25] == 1'b0, "R11 no further polls", frames - f, 0);

        // R12 host start during poll spacing goes first
        wr(2'd0, 32'd1 << 28);
        wait_busy(1'b1);
        wait_busy(1'b0);
        f = frames;
        host_read(5'd3, 1'b1);
        chk(frames == f + 1 && last_reg == 5'd3, "R12 host before poll", {27'(frames - f), last_reg}, {27'd1, 5'd3});
        wr(2'd0, 32'd0);
        wait_busy(1'b0);

        chk(frame_err == 0, "R2 frame format", frame_err, 0);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule